// File: doc/BRIEF.md
# Read Completion Splitter

This block sits behind the transaction layer of a serial-bus endpoint. It takes one decoded incoming request at a time and turns it into the sequence of completion headers that answer it. Each request carries a kind, a requester ID, a tag, a start address, a length in doublewords, and an error indication. Posted memory writes are absorbed silently. I/O writes and failed requests are answered with a single completion that has no data. Memory reads are cut into several data completions.

The cut points follow two configuration inputs: a maximum payload code and a completion boundary select. The first piece of an unaligned read stops at the next boundary. Every later piece is as large as the payload limit allows. For each header the block computes the doubleword length, the remaining byte count and the lower-address field. Fetching the payload, link framing and credit accounting belong to neighbouring blocks.

The request side has a valid/ready handshake. The completion side presents one header at a time with a valid/ready handshake. The configuration inputs must stay stable while a request is being answered.

Top module: `cpl_splitter`

## Requirements
- R1: A request of kind 0 (posted memory write) is accepted and produces no completion, whatever its error input.
- R2: The data carried by one completion never exceeds the payload limit. Limit codes 0..5 select 128, 256, 512, 1024, 2048 and 4096 bytes, and codes 6 and 7 act as 128 bytes.
- R3: Within a split memory read, every completion after the first starts on an address that is a multiple of the boundary. The boundary is 64 bytes when `cfg_rcb_sel` is 0 and 128 bytes when it is 1.
- R4: The 7-bit lower-address field is zero for I/O requests (kinds 2 and 3). For memory requests it equals address bits 6:0 of the first byte that completion carries.
- R5: The byte-count field equals the bytes still owed for the whole request, counted from that completion's first byte. A 1024-doubleword read starts at 4096.
- R6: A request with `req_err` set (kinds 1 to 3) yields exactly one completion with no data and length 0. Its status is 001 when `req_err_ca` is 0 and 100 when it is 1. Its byte count is the request's total bytes (4 for I/O).
- R7: A successful completion carries status 000.
- R8: The length field is in doublewords, and a 1024-doubleword completion is encoded as 0.
- R9: An I/O read (kind 2) yields one 1-doubleword data completion. An I/O write (kind 3) yields one completion without data. Both have byte count 4.
- R10: When a memory read starts off the boundary, its first completion carries only the bytes up to the next boundary. After that, each completion carries the payload limit or the remainder, whichever is smaller. `cpl_last` marks the final completion.
- R11: While `cpl_valid` is high and `cpl_ready` is low, every completion output holds its value.
- R12: `req_ready` is low from the cycle a request producing completions is accepted until its last completion is taken.
- R13: After reset, `cpl_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 2 | 0 mem write, 1 mem read, 2 I/O read, 3 I/O write |
| req_rid | input | 16 | Requester ID |
| req_tag | input | 8 | Request tag |
| req_addr | input | 32 | Start byte address, doubleword aligned |
| req_len_dw | input | 10 | Length in doublewords, 0 means 1024 |
| req_err | input | 1 | Request could not be processed |
| req_err_ca | input | 1 | Error kind: 0 unsupported, 1 completer abort |
| cfg_mps_code | input | 3 | Payload limit code |
| cfg_rcb_sel | input | 1 | Completion boundary: 0 = 64 B, 1 = 128 B |
| cpl_valid | output | 1 | Completion header present |
| cpl_ready | input | 1 | Consumer takes the header |
| cpl_status | output | 3 | Completion status |
| cpl_rid | output | 16 | Requester ID echoed |
| cpl_tag | output | 8 | Tag echoed |
| cpl_has_data | output | 1 | Header carries payload |
| cpl_len_dw | output | 10 | Payload length in doublewords |
| cpl_byte_cnt | output | 13 | Bytes remaining, including this completion |
| cpl_lower_addr | output | 7 | Lower address field |
| cpl_last | output | 1 | Final completion of the request |

## Verification
Memory reads are applied with aligned and unaligned start addresses under both boundary settings. This separates the short boundary-reaching first piece from the full payload-sized pieces that follow. Several payload codes are tried, including a reserved one and the 4096-byte limit with a 1024-doubleword read, which exposes length encoding and byte-count chaining errors. I/O reads, I/O writes, both error kinds and posted writes check the no-data paths, the status codes and the forced-zero lower address. A back-pressured read shows that headers hold steady while stalled.

// File: rtl/cpl_pkg.sv
// Shared types and constants for the completion splitter.
package cpl_pkg;
    typedef enum logic [1:0] {
        KIND_MEM_WR = 2'd0,
        KIND_MEM_RD = 2'd1,
        KIND_IO_RD  = 2'd2,
        KIND_IO_WR  = 2'd3
    } req_kind_t;

    localparam logic [2:0] STAT_SC = 3'b000;
    localparam logic [2:0] STAT_UR = 3'b001;
    localparam logic [2:0] STAT_CA = 3'b100;
endpackage

// File: rtl/cpl_limit_decode.sv
// Decodes the payload limit code and the boundary select into byte counts.
// Assumes: codes above 5 are reserved and fall back to the smallest limit.
module cpl_limit_decode #(
    parameter int BCNT_W = 13
) (
    input  logic [2:0]        mps_code,
    input  logic              rcb_sel,
    output logic [BCNT_W-1:0] mps_bytes,
    output logic [BCNT_W-1:0] rcb_bytes
);
    localparam logic [BCNT_W-1:0] MPS_MIN = BCNT_W'(128);

    // Payload limit: 128 bytes shifted by the code, reserved codes clamp.
    always_comb begin
        if (mps_code > 3'd5) mps_bytes = MPS_MIN;
        else                 mps_bytes = MPS_MIN << mps_code;
    end

    // Boundary: 64 or 128 bytes.
    always_comb rcb_bytes = rcb_sel ? BCNT_W'(128) : BCNT_W'(64);
endmodule

// File: rtl/cpl_chunk_calc.sv
// Sizes the next completion from the current address and remaining bytes.
// Assumes: addresses are doubleword aligned and the payload limit is a
// multiple of the boundary, so after the first piece alignment is kept.
module cpl_chunk_calc #(
    parameter int BCNT_W = 13,
    parameter int LA_W   = 7
) (
    input  logic [LA_W-1:0]   addr_low,
    input  logic [BCNT_W-1:0] rem_bytes,
    input  logic              first,
    input  logic [BCNT_W-1:0] mps_bytes,
    input  logic [BCNT_W-1:0] rcb_bytes,
    output logic [BCNT_W-1:0] chunk
);
    logic [BCNT_W-1:0] off;
    logic [BCNT_W-1:0] lim;

    // Offset of the address inside its boundary block.
    always_comb off = BCNT_W'(addr_low) & (rcb_bytes - BCNT_W'(1));

    // Limit for this piece: reach the boundary first, then full payloads.
    always_comb begin
        if (first && off != '0) lim = rcb_bytes - off;
        else                    lim = mps_bytes;
        chunk = (rem_bytes < lim) ? rem_bytes : lim;
    end
endmodule

// File: rtl/cpl_hdr_format.sv
// Forms the per-completion header fields from the request context.
// Assumes: chunk never exceeds 4096 bytes, so length bits above 10 drop.
module cpl_hdr_format #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10,
    parameter int BCNT_W = LEN_W + 3,
    parameter int LA_W   = 7
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [BCNT_W-1:0] rem_bytes,
    input  logic [BCNT_W-1:0] chunk,
    input  logic              is_io,
    input  logic              no_data,
    output logic [LEN_W-1:0]  len_dw,
    output logic [BCNT_W-1:0] byte_cnt,
    output logic [LA_W-1:0]   lower_addr,
    output logic              last
);
    // Length in doublewords; 1024 wraps to zero in the field width.
    always_comb len_dw = no_data ? '0 : chunk[LEN_W+1:2];

    // Remaining bytes are reported from this completion's first byte.
    always_comb byte_cnt = rem_bytes;

    // Lower address follows the request kind.
    always_comb lower_addr = is_io ? '0 : cur_addr[LA_W-1:0];

    // Final piece once the chunk covers what is owed.
    always_comb last = no_data || (chunk == rem_bytes);
endmodule

// File: rtl/cpl_splitter.sv
// Turns one decoded request into its completion headers, one per handshake.
// Assumes: configuration is stable while busy; I/O requests are 1 doubleword.
module cpl_splitter #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 10,
    parameter int RID_W  = 16,
    parameter int TAG_W  = 8,
    parameter int LA_W   = 7,
    parameter int BCNT_W = LEN_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len_dw,
    input  logic              req_err,
    input  logic              req_err_ca,
    input  logic [2:0]        cfg_mps_code,
    input  logic              cfg_rcb_sel,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic [2:0]        cpl_status,
    output logic [RID_W-1:0]  cpl_rid,
    output logic [TAG_W-1:0]  cpl_tag,
    output logic              cpl_has_data,
    output logic [LEN_W-1:0]  cpl_len_dw,
    output logic [BCNT_W-1:0] cpl_byte_cnt,
    output logic [LA_W-1:0]   cpl_lower_addr,
    output logic              cpl_last
);
    import cpl_pkg::*;

    localparam logic [BCNT_W-1:0] DW_BYTES = BCNT_W'(4);

    logic              busy_q, first_q, io_q, nodata_q;
    logic [2:0]        status_q;
    logic [RID_W-1:0]  rid_q;
    logic [TAG_W-1:0]  tag_q;
    logic [ADDR_W-1:0] cur_q;
    logic [BCNT_W-1:0] rem_q;
    logic [BCNT_W-1:0] mps_bytes, rcb_bytes, chunk_raw, chunk;
    logic [BCNT_W-1:0] req_bytes;
    logic              accept, take, last;
    req_kind_t         kind;

    cpl_limit_decode #(.BCNT_W(BCNT_W)) u_limits (
        .mps_code (cfg_mps_code),
        .rcb_sel  (cfg_rcb_sel),
        .mps_bytes(mps_bytes),
        .rcb_bytes(rcb_bytes)
    );

    cpl_chunk_calc #(.BCNT_W(BCNT_W), .LA_W(LA_W)) u_chunk (
        .addr_low (cur_q[LA_W-1:0]),
        .rem_bytes(rem_q),
        .first    (first_q),
        .mps_bytes(mps_bytes),
        .rcb_bytes(rcb_bytes),
        .chunk    (chunk_raw)
    );

    // No-data completions consume the whole remainder in one step.
    always_comb chunk = nodata_q ? rem_q : chunk_raw;

    cpl_hdr_format #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BCNT_W(BCNT_W), .LA_W(LA_W)) u_hdr (
        .cur_addr  (cur_q),
        .rem_bytes (rem_q),
        .chunk     (chunk),
        .is_io     (io_q),
        .no_data   (nodata_q),
        .len_dw    (cpl_len_dw),
        .byte_cnt  (cpl_byte_cnt),
        .lower_addr(cpl_lower_addr),
        .last      (last)
    );

    // Handshake decode and request size in bytes (zero length means 1024 DW).
    always_comb begin
        kind      = req_kind_t'(req_kind);
        accept    = req_valid && !busy_q;
        take      = busy_q && cpl_ready;
        req_bytes = (req_len_dw == '0) ? (BCNT_W'(1) << (LEN_W + 2))
                                       : {1'b0, req_len_dw, 2'b00};
    end

    // Request context: loaded on accept, advanced on each taken completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            first_q  <= 1'b0;
            io_q     <= 1'b0;
            nodata_q <= 1'b0;
            status_q <= STAT_SC;
            rid_q    <= '0;
            tag_q    <= '0;
            cur_q    <= '0;
            rem_q    <= '0;
        end else if (accept) begin
            if (kind != KIND_MEM_WR) begin
                busy_q   <= 1'b1;
                first_q  <= 1'b1;
                io_q     <= req_kind[1];
                nodata_q <= req_err || (kind == KIND_IO_WR);
                status_q <= !req_err ? STAT_SC : (req_err_ca ? STAT_CA : STAT_UR);
                rid_q    <= req_rid;
                tag_q    <= req_tag;
                cur_q    <= req_addr;
                rem_q    <= req_kind[1] ? DW_BYTES : req_bytes;
            end
        end else if (take) begin
            if (last) begin
                busy_q <= 1'b0;
            end else begin
                first_q <= 1'b0;
                cur_q   <= cur_q + ADDR_W'(chunk);
                rem_q   <= rem_q - chunk;
            end
        end
    end

    // Port outputs driven from the held context.
    always_comb begin
        req_ready    = !busy_q;
        cpl_valid    = busy_q;
        cpl_status   = status_q;
        cpl_rid      = rid_q;
        cpl_tag      = tag_q;
        cpl_has_data = !nodata_q;
        cpl_last     = last;
    end
endmodule

// File: rtl/cpl_splitter_chk.sv
// Protocol checker for cpl_splitter, attached by bind below.
// Assumes: configuration inputs are stable while a request is answered.
module cpl_splitter_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [1:0]  req_kind,
    input logic [31:0] req_addr,
    input logic [2:0]  cfg_mps_code,
    input logic        cfg_rcb_sel,
    input logic        cpl_valid,
    input logic        cpl_ready,
    input logic [2:0]  cpl_status,
    input logic [15:0] cpl_rid,
    input logic [7:0]  cpl_tag,
    input logic        cpl_has_data,
    input logic [9:0]  cpl_len_dw,
    input logic [12:0] cpl_byte_cnt,
    input logic [6:0]  cpl_lower_addr,
    input logic        cpl_last
);
    logic [12:0] len_b, mps_b;
    logic [6:0]  rcb_mask;
    logic        cont_q, io_q;
    logic [6:0]  addr_q;

    // Independent decode of the header length and the limits.
    always_comb begin
        len_b    = (cpl_len_dw == 10'd0) ? 13'd4096 : {1'b0, cpl_len_dw, 2'b00};
        mps_b    = (cfg_mps_code > 3'd5) ? 13'd128 : (13'd128 << cfg_mps_code);
        rcb_mask = cfg_rcb_sel ? 7'h7f : 7'h3f;
    end

    // Track the request kind, start address and whether a piece was taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q <= 1'b0;
            io_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            if (req_valid && req_ready) begin
                io_q   <= req_kind[1];
                addr_q <= req_addr[6:0];
            end
            if (cpl_valid && cpl_ready) cont_q <= !cpl_last;
        end
    end

    assert_reset_idle_R13: assert property (@(posedge clk)
        $rose(rst_n) |-> (!cpl_valid && req_ready));

    assert_posted_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'd0) |=> (!cpl_valid && req_ready));

    assert_payload_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_has_data) |-> (len_b <= mps_b));

    assert_split_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cont_q) |-> ((cpl_lower_addr & rcb_mask) == 7'd0));

    assert_io_la_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && io_q) |-> (cpl_lower_addr == 7'd0));

    assert_mem_first_la_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !io_q && !cont_q) |-> (cpl_lower_addr == addr_q));

    assert_bytecount_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready && !cpl_last) |=>
        (cpl_valid && cpl_byte_cnt == $past(cpl_byte_cnt) - $past(len_b)));

    assert_last_covers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_has_data && cpl_last) |-> (cpl_byte_cnt == len_b));

    assert_error_nodata_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_status != 3'b000) |->
        (!cpl_has_data && cpl_last && cpl_len_dw == 10'd0));

    assert_status_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> (cpl_status == 3'b000 || cpl_status == 3'b001 || cpl_status == 3'b100));

    assert_hold_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=>
        (cpl_valid && $stable(cpl_status) && $stable(cpl_rid) && $stable(cpl_tag) &&
         $stable(cpl_has_data) && $stable(cpl_len_dw) && $stable(cpl_byte_cnt) &&
         $stable(cpl_lower_addr) && $stable(cpl_last)));

    assert_ready_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid |-> !req_ready);
endmodule

bind cpl_splitter cpl_splitter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .cfg_mps_code(cfg_mps_code),
    .cfg_rcb_sel(cfg_rcb_sel), .cpl_valid(cpl_valid), .cpl_ready(cpl_ready),
    .cpl_status(cpl_status), .cpl_rid(cpl_rid), .cpl_tag(cpl_tag),
    .cpl_has_data(cpl_has_data), .cpl_len_dw(cpl_len_dw),
    .cpl_byte_cnt(cpl_byte_cnt), .cpl_lower_addr(cpl_lower_addr),
    .cpl_last(cpl_last)
);

// File: tb/cpl_splitter_test.sv
// Directed bench: one task per scenario, each checking its own completions.
module cpl_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [15:0] req_rid = '0;
    logic [7:0]  req_tag = '0;
    logic [31:0] req_addr = '0;
    logic [9:0]  req_len_dw = '0;
    logic        req_err = 1'b0;
    logic        req_err_ca = 1'b0;
    logic [2:0]  cfg_mps_code = '0;
    logic        cfg_rcb_sel = 1'b0;
    logic        cpl_valid;
    logic        cpl_ready = 1'b0;
    logic [2:0]  cpl_status;
    logic [15:0] cpl_rid;
    logic [7:0]  cpl_tag;
    logic        cpl_has_data;
    logic [9:0]  cpl_len_dw;
    logic [12:0] cpl_byte_cnt;
    logic [6:0]  cpl_lower_addr;
    logic        cpl_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cpl_splitter uut (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Present one request for one cycle; it is taken because the block is idle.
    task automatic send(input logic [1:0] kind, input logic [31:0] addr,
                        input logic [9:0] len, input bit err, input bit ca,
                        input logic [7:0] tag);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_len_dw = len;
        req_err = err; req_err_ca = ca; req_tag = tag; req_rid = {8'hA5, tag};
        @(negedge clk);
        req_valid = 1'b0; req_err = 1'b0;
    endtask

    // Compare the presented header with the expected one, then take it.
    task automatic expect_cpl(input string req, input logic [2:0] st, input bit hd,
                              input logic [9:0] len, input logic [12:0] bc,
                              input logic [6:0] la, input bit last, input logic [7:0] tag,
                              input int stall);
        for (int s = 0; s < stall; s++) begin
            cpl_ready = 1'b0;
            @(negedge clk);
        end
        check(cpl_valid == 1'b1, {req, " valid"}, 64'(cpl_valid), 64'd1);
        check({cpl_status, cpl_has_data, cpl_len_dw, cpl_byte_cnt, cpl_lower_addr,
               cpl_last, cpl_tag, cpl_rid} ==
              {st, hd, len, bc, la, last, tag, 8'hA5, tag}, req,
              {cpl_status, cpl_has_data, cpl_len_dw, cpl_byte_cnt, cpl_lower_addr,
               cpl_last, cpl_tag},
              {st, hd, len, bc, la, last, tag});
        cpl_ready = 1'b1;
        @(negedge clk);
        cpl_ready = 1'b0;
    endtask

    task automatic expect_idle(input string req);
        check(cpl_valid == 1'b0 && req_ready == 1'b1, req,
              {cpl_valid, req_ready}, 64'b01);
    endtask

    // Memory read: expected pieces come from the splitting rules.
    task automatic t_mem_read(input string req, input logic [31:0] addr,
                              input logic [9:0] len, input logic [2:0] code,
                              input bit rcb_sel, input int stall, input logic [7:0] tag);
        int rem, cur, mps, rcb, c;
        bit first;
        cfg_mps_code = code; cfg_rcb_sel = rcb_sel;
        mps = (code > 5) ? 128 : (128 << code);
        rcb = rcb_sel ? 128 : 64;
        rem = (len == 0) ? 4096 : int'(len) * 4;
        cur = int'(addr);
        first = 1'b1;
        send(2'd1, addr, len, 1'b0, 1'b0, tag);
        while (rem > 0) begin
            if (first && (cur % rcb) != 0) c = rcb - (cur % rcb);
            else                          c = mps;
            if (c > rem) c = rem;
            expect_cpl(req, 3'b000, 1'b1, 10'(c / 4), 13'(rem), 7'(cur),
                       rem == c, tag, stall);
            rem -= c; cur += c; first = 1'b0;
        end
        expect_idle({req, " idle after"});
    endtask

    task automatic t_reset();
        // R13: idle after reset
        expect_idle("R13 reset");
    endtask

    task automatic t_posted();
        send(2'd0, 32'h100, 10'd8, 1'b0, 1'b0, 8'h01);
        expect_idle("R1 posted write");
        send(2'd0, 32'h200, 10'd4, 1'b1, 1'b1, 8'h02);
        @(negedge clk);
        expect_idle("R1 posted write with error");
    endtask

    task automatic t_io();
        send(2'd2, 32'h0000_0F14, 10'd1, 1'b0, 1'b0, 8'h10);
        expect_cpl("R9 R4 io read", 3'b000, 1'b1, 10'd1, 13'd4, 7'd0, 1'b1, 8'h10, 0);
        expect_idle("R9 io read single");
        send(2'd3, 32'h0000_0F24, 10'd1, 1'b0, 1'b0, 8'h11);
        expect_cpl("R9 R4 io write", 3'b000, 1'b0, 10'd0, 13'd4, 7'd0, 1'b1, 8'h11, 0);
        expect_idle("R9 io write single");
    endtask

    task automatic t_errors();
        cfg_mps_code = 3'd0; cfg_rcb_sel = 1'b0;
        send(2'd1, 32'h0000_1044, 10'd100, 1'b1, 1'b0, 8'h20);
        expect_cpl("R6 unsupported mem read", 3'b001, 1'b0, 10'd0, 13'd400, 7'h44,
                   1'b1, 8'h20, 0);
        expect_idle("R6 single error completion");
        send(2'd2, 32'h0000_0008, 10'd1, 1'b1, 1'b1, 8'h21);
        expect_cpl("R6 abort io read", 3'b100, 1'b0, 10'd0, 13'd4, 7'd0, 1'b1, 8'h21, 0);
        send(2'd3, 32'h0000_000C, 10'd1, 1'b1, 1'b0, 8'h22);
        expect_cpl("R6 unsupported io write", 3'b001, 1'b0, 10'd0, 13'd4, 7'd0,
                   1'b1, 8'h22, 0);
    endtask

    task automatic t_stall_hold();
        // R11: header held over stalled cycles, compared after the stall
        t_mem_read("R11 R5 stalled read", 32'h0000_2000, 10'd96, 3'd1, 1'b0, 3, 8'h30);
    endtask

    task automatic t_busy_gate();
        cfg_mps_code = 3'd0; cfg_rcb_sel = 1'b0;
        send(2'd1, 32'h0000_3000, 10'd64, 1'b0, 1'b0, 8'h40);
        // R12: a new request is refused while completions are owed
        check(req_ready == 1'b0, "R12 ready low while busy", 64'(req_ready), 64'd0);
        expect_cpl("R12 piece 1", 3'b000, 1'b1, 10'd32, 13'd256, 7'h00, 1'b0, 8'h40, 0);
        check(req_ready == 1'b0, "R12 ready low between pieces", 64'(req_ready), 64'd0);
        expect_cpl("R12 piece 2", 3'b000, 1'b1, 10'd32, 13'd128, 7'h00, 1'b1, 8'h40, 0);
        expect_idle("R12 ready after last");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_posted();
        // R7 R10 R3: unaligned start, 64-byte boundary, 128-byte limit
        t_mem_read("R10 R3 R7 unaligned rcb64", 32'h0000_1034, 10'd80, 3'd0, 1'b0, 0, 8'h50);
        // R10 R3: unaligned start, 128-byte boundary, 512-byte limit
        t_mem_read("R10 R3 unaligned rcb128", 32'h0000_40C8, 10'd300, 3'd2, 1'b1, 0, 8'h51);
        // R2: reserved limit code acts as 128 bytes
        t_mem_read("R2 reserved code", 32'h0000_5000, 10'd64, 3'd7, 1'b0, 0, 8'h52);
        // R2 R4: 2048-byte limit, short read inside one boundary block
        t_mem_read("R2 R4 short read", 32'h0000_6008, 10'd3, 3'd4, 1'b1, 0, 8'h53);
        // R8 R5: 1024 doublewords in one 4096-byte piece, length encodes as 0
        t_mem_read("R8 R5 full page", 32'h0001_0000, 10'd0, 3'd5, 1'b0, 0, 8'h54);
        // R8 R5: 1024 doublewords split at 1024 bytes
        t_mem_read("R8 R5 page split", 32'h0002_0000, 10'd0, 3'd3, 1'b1, 0, 8'h55);
        t_io();
        t_errors();
        t_stall_hold();
        t_busy_gate();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=done", checks);
        finish_run();
    end
endmodule